// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Function Select

This block is a memory-mapped general-purpose I/O controller for up to 63 pins. Software reaches it over a simple word-addressed register bus with one access per cycle. Outputs can be written as whole words. They can also be changed bit by bit through a write-one-to-set port and a write-one-to-clear port. A direction mask chooses which pins drive their pads. Each pin carries a two-bit function code that routes the pad to one of four uses, and function code 0 is plain GPIO.

Every per-pin register is banked across two 32-bit words. Pin p sits in the low word when p is below 32, and in the high word otherwise, at bit p mod 32. The function code is held in two bit-plane registers. A pin's code can therefore pass through an intermediate value while software updates the two planes in separate bus cycles. Pad inputs go through a two-flop synchronizer before software can see them.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset, pad_out_o, pad_oe_o and pad_func_o are all 0, so every pin is an input with function code 0.
- R2: Word addresses: 0/1 output value, 2/3 output set, 4/5 output clear, 6/7 output enable, 8/9 pin level, 10 function plane 0 (low pins), 11 function plane 1 (low pins), 12 function plane 0 (high pins), 13 function plane 1 (high pins). The lower address of each pair covers pins 0-31 and the upper covers pins 32-62. Pin p maps to bit p mod 32.
- R3: For each 1 bit written to the output-set word, the matching output latch becomes 1 on the next clock. Latches at 0 bits of the write are unchanged.
- R4: For each 1 bit written to the output-clear word, the matching output latch becomes 0 on the next clock. Latches at 0 bits of the write are unchanged.
- R5: A write to an output-value word replaces all bits of that word. A read of it returns the latches.
- R6: A 1 in an output-enable bit drives pad_oe_o for that pin high, which makes the pin an output. The word reads back as written.
- R7: The pin-level word returns the output latch for pins whose enable bit is 1, and the synchronized pad input for pins whose enable bit is 0.
- R8: A pad input change reaches the pin-level read path two clocks after it is first sampled. A read completing at the first or second edge after the change returns the old value, and a read at the third edge returns the new one.
- R9: pad_func_o[2p+1:2p] = {plane1 bit, plane0 bit} for pin p. Both plane registers read back as written.
- R10: A write to one function plane changes only that bit of each pin's code. The intermediate code appears on pad_func_o until the other plane is written.
- R11: Bit 31 of every high-pin word does not exist. It reads 0 and ignores writes.
- R12: Reads of the set, clear and unmapped addresses (14 and above) return 0. Writes to the pin-level, unmapped addresses have no effect on any pad output.
- R13: rdata_o is registered. It takes the read result at the edge that accepts a read (req_i=1, we_i=0) and holds its value at all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (6) | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pad_in_i | input | NUM_PINS (63) | Pad input levels |
| pad_out_o | output | NUM_PINS (63) | Pad output values |
| pad_oe_o | output | NUM_PINS (63) | Pad output enables |
| pad_func_o | output | 2*NUM_PINS (126) | Per-pin function codes |

## Verification
The bench sets single bits with the set and clear ports next to latches that are already 1 or 0. A design that rewrote the whole word, or treated a 0 bit as a command, would disturb neighbouring pins. It mixes enabled and non-enabled pins in one level read, which catches a wrong select between latch and input. It times a pad edge against back-to-back reads, so one synchronizer flop too many or too few shows up.

The bench writes one function plane at a time. This exposes a design that derived both code bits from one register, and one that swapped the plane order. It drives all ones into the missing top bit and into unmapped and read-only addresses. A design that stored, echoed or aliased those writes would then produce nonzero reads or changed pads.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned EXT_W    = 64;
  localparam int unsigned NUM_REGS = 14;

  typedef enum logic [3:0] {
    RG_OUT_LO = 4'd0,
    RG_OUT_HI = 4'd1,
    RG_SET_LO = 4'd2,
    RG_SET_HI = 4'd3,
    RG_CLR_LO = 4'd4,
    RG_CLR_HI = 4'd5,
    RG_OE_LO  = 4'd6,
    RG_OE_HI  = 4'd7,
    RG_LVL_LO = 4'd8,
    RG_LVL_HI = 4'd9,
    RG_F0_LO  = 4'd10,
    RG_F1_LO  = 4'd11,
    RG_F0_HI  = 4'd12,
    RG_F1_HI  = 4'd13
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank_reg.sv
module gpio_bank_reg
  import gpio_mux_pkg::*;
#(
  parameter int unsigned N_BITS = 63,
  parameter bit          HAS_SC = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        wr_i,
  input  logic [1:0]        set_i,
  input  logic [1:0]        clr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [N_BITS-1:0] q_o
);
  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    localparam int unsigned BK = i / WORD_W;
    localparam int unsigned BT = i % WORD_W;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     q_o[i] <= 1'b0;
      else if (wr_i[BK])                               q_o[i] <= wdata_i[BT];
      else if (HAS_SC && set_i[BK] && wdata_i[BT])     q_o[i] <= 1'b1;
      else if (HAS_SC && clr_i[BK] && wdata_i[BT])     q_o[i] <= 1'b0;
    end

    assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (HAS_SC && set_i[BK] && wdata_i[BT] && !wr_i[BK]) |=> q_o[i]);

    assert_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (HAS_SC && clr_i[BK] && wdata_i[BT] && !wr_i[BK] && !set_i[BK]) |=> !q_o[i]);

    // untouched bank keeps its bits
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i[BK] || set_i[BK] || clr_i[BK]) |=> $stable(q_o[i]));
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_mux_pkg::*;
#(
  parameter int unsigned N_BITS = 63
) (
  input  logic              hit_i,
  input  reg_sel_e          sel_i,
  input  logic [N_BITS-1:0] out_i,
  input  logic [N_BITS-1:0] oe_i,
  input  logic [N_BITS-1:0] lvl_i,
  input  logic [N_BITS-1:0] f0_i,
  input  logic [N_BITS-1:0] f1_i,
  output logic [WORD_W-1:0] word_o
);
  function automatic logic [EXT_W-1:0] ext(input logic [N_BITS-1:0] v);
    logic [EXT_W-1:0] r;
    r = '0;
    r[N_BITS-1:0] = v;
    return r;
  endfunction

  logic [EXT_W-1:0] out_x, oe_x, lvl_x, f0_x, f1_x;

  always_comb begin
    out_x = ext(out_i);
    oe_x  = ext(oe_i);
    lvl_x = ext(lvl_i);
    f0_x  = ext(f0_i);
    f1_x  = ext(f1_i);
    word_o = '0;
    if (hit_i) begin
      case (sel_i)
        RG_OUT_LO: word_o = out_x[31:0];
        RG_OUT_HI: word_o = out_x[63:32];
        RG_OE_LO:  word_o = oe_x[31:0];
        RG_OE_HI:  word_o = oe_x[63:32];
        RG_LVL_LO: word_o = lvl_x[31:0];
        RG_LVL_HI: word_o = lvl_x[63:32];
        RG_F0_LO:  word_o = f0_x[31:0];
        RG_F1_LO:  word_o = f1_x[31:0];
        RG_F0_HI:  word_o = f0_x[63:32];
        RG_F1_HI:  word_o = f1_x[63:32];
        default:   word_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 63,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [WORD_W-1:0]     wdata_i,
  output logic [WORD_W-1:0]     rdata_o,
  input  logic [NUM_PINS-1:0]   pad_in_i,
  output logic [NUM_PINS-1:0]   pad_out_o,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic [2*NUM_PINS-1:0] pad_func_o
);
  logic          hit, wr, rd;
  reg_sel_e      sel;
  logic [1:0]    out_wr, set_wr, clr_wr, oe_wr, f0_wr, f1_wr;
  logic [NUM_PINS-1:0] out_q, oe_q, f0_q, f1_q, in_sync, lvl;
  logic [WORD_W-1:0]   rd_word, rdata_q;

  assign hit = (addr_i < ADDR_W'(NUM_REGS));
  assign sel = reg_sel_e'(addr_i[3:0]);
  assign wr  = req_i && we_i && hit;
  assign rd  = req_i && !we_i;

  assign out_wr = {wr && sel == RG_OUT_HI, wr && sel == RG_OUT_LO};
  assign set_wr = {wr && sel == RG_SET_HI, wr && sel == RG_SET_LO};
  assign clr_wr = {wr && sel == RG_CLR_HI, wr && sel == RG_CLR_LO};
  assign oe_wr  = {wr && sel == RG_OE_HI,  wr && sel == RG_OE_LO};
  assign f0_wr  = {wr && sel == RG_F0_HI,  wr && sel == RG_F0_LO};
  assign f1_wr  = {wr && sel == RG_F1_HI,  wr && sel == RG_F1_LO};

  gpio_bank_reg #(.N_BITS(NUM_PINS), .HAS_SC(1'b1)) u_out (
    .clk_i, .rst_ni, .wr_i(out_wr), .set_i(set_wr), .clr_i(clr_wr),
    .wdata_i, .q_o(out_q));

  gpio_bank_reg #(.N_BITS(NUM_PINS), .HAS_SC(1'b0)) u_oe (
    .clk_i, .rst_ni, .wr_i(oe_wr), .set_i(2'b00), .clr_i(2'b00),
    .wdata_i, .q_o(oe_q));

  gpio_bank_reg #(.N_BITS(NUM_PINS), .HAS_SC(1'b0)) u_f0 (
    .clk_i, .rst_ni, .wr_i(f0_wr), .set_i(2'b00), .clr_i(2'b00),
    .wdata_i, .q_o(f0_q));

  gpio_bank_reg #(.N_BITS(NUM_PINS), .HAS_SC(1'b0)) u_f1 (
    .clk_i, .rst_ni, .wr_i(f1_wr), .set_i(2'b00), .clr_i(2'b00),
    .wdata_i, .q_o(f1_q));

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(in_sync));

  // driven pins report their own latch
  assign lvl = (oe_q & out_q) | (~oe_q & in_sync);

  gpio_read_mux #(.N_BITS(NUM_PINS)) u_rmux (
    .hit_i(hit), .sel_i(sel), .out_i(out_q), .oe_i(oe_q), .lvl_i(lvl),
    .f0_i(f0_q), .f1_i(f1_q), .word_o(rd_word));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_word;
  end

  assign rdata_o   = rdata_q;
  assign pad_out_o = out_q;
  assign pad_oe_o  = oe_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_func
    assign pad_func_o[2*p +: 2] = {f1_q[p], f0_q[p]};
  end

  assert_rd_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));

  assert_sc_read_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit && (sel inside {RG_SET_LO, RG_SET_HI, RG_CLR_LO, RG_CLR_HI}))
      |=> (rdata_o == '0));

  assert_unmapped_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit) |=> ($stable(pad_out_o) && $stable(pad_oe_o) && $stable(pad_func_o)));

  assert_oe_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && hit && (sel inside {RG_OE_LO, RG_OE_HI})) |=> $stable(pad_oe_o));

  assert_plane_split_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && sel == RG_F0_LO) |=> $stable(pad_func_o[1]));

  if (NUM_PINS < 64) begin : g_top_bit
    assert_top_bit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd && hit && (sel inside {RG_OUT_HI, RG_OE_HI, RG_LVL_HI, RG_F0_HI, RG_F1_HI}))
        |=> !rdata_o[31]);
  end
endmodule

// File: tb/gpio_mux_ctrl_test.sv
`timescale 1ns/1ps
module gpio_mux_ctrl_test;
  localparam int N = 63;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [5:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic [2*N-1:0] pad_func;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_mux_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_func_o(pad_func));

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pad_out", 128'(pad_out), 128'(0));
    chk("R1 pad_oe", 128'(pad_oe), 128'(0));
    chk("R1 pad_func", 128'(pad_func), 128'(0));
    rd(6'd0, d); chk("R1 out_lo read", 128'(d), 128'(0));
  endtask

  task automatic t_full_word();
    logic [31:0] d;
    wr(6'd0, 32'hA5A5_0F0F);
    wr(6'd1, 32'h1234_5678);
    chk("R5 R2 pad_out", 128'(pad_out), 128'({31'h1234_5678, 32'hA5A5_0F0F}));
    rd(6'd0, d); chk("R5 out_lo read", 128'(d), 128'(32'hA5A5_0F0F));
    rd(6'd1, d); chk("R5 out_hi read", 128'(d), 128'(32'h1234_5678));
  endtask

  task automatic t_set_clr();
    logic [31:0] d;
    logic [N-1:0] e;
    wr(6'd0, 32'h0000_0001);
    wr(6'd1, 32'h0000_0000);
    wr(6'd2, 32'h0000_00F0);
    e = 63'h0000_0000_0000_00F1;
    chk("R3 set low bits", 128'(pad_out), 128'(e));
    wr(6'd3, 32'h4000_0001);
    e[62] = 1'b1; e[32] = 1'b1;
    chk("R3 set high bits", 128'(pad_out), 128'(e));
    wr(6'd4, 32'h0000_0030);
    e[5:4] = 2'b00;
    chk("R4 clear low bits", 128'(pad_out), 128'(e));
    wr(6'd5, 32'h4000_0000);
    e[62] = 1'b0;
    chk("R4 clear pin62", 128'(pad_out), 128'(e));
    rd(6'd2, d); chk("R12 set read zero", 128'(d), 128'(0));
    rd(6'd5, d); chk("R12 clear read zero", 128'(d), 128'(0));
  endtask

  task automatic t_oe_level();
    logic [31:0] d;
    wr(6'd0, 32'h0000_00FF);
    wr(6'd1, 32'h0000_0000);
    wr(6'd6, 32'h0000_000F);
    wr(6'd7, 32'h0000_0000);
    chk("R6 pad_oe", 128'(pad_oe), 128'(63'h0F));
    rd(6'd6, d); chk("R6 oe read", 128'(d), 128'(32'h0000_000F));
    pad_in = '0;
    pad_in[11:8] = 4'hF; pad_in[5:4] = 2'b11; pad_in[32] = 1'b1; pad_in[62] = 1'b1;
    idle(3);
    rd(6'd8, d); chk("R7 level low", 128'(d), 128'(32'h0000_0F3F));
    rd(6'd9, d); chk("R7 level high", 128'(d), 128'(32'h4000_0001));
  endtask

  task automatic t_sync_latency();
    logic [31:0] d1, d2, d3;
    wr(6'd6, 32'h0);
    pad_in = '0;
    idle(3);
    pad_in[0] = 1'b1;
    rd(6'd8, d1);
    rd(6'd8, d2);
    rd(6'd8, d3);
    chk("R8 first edge old", 128'(d1[0]), 128'(0));
    chk("R8 second edge old", 128'(d2[0]), 128'(0));
    chk("R8 third edge new", 128'(d3[0]), 128'(1));
  endtask

  task automatic t_top_bit();
    logic [31:0] d;
    wr(6'd1, 32'hFFFF_FFFF);
    rd(6'd1, d); chk("R11 out_hi bit31", 128'(d), 128'(32'h7FFF_FFFF));
    chk("R11 pad_out high", 128'(pad_out[62:32]), 128'(31'h7FFF_FFFF));
    wr(6'd7, 32'hFFFF_FFFF);
    rd(6'd7, d); chk("R11 oe_hi bit31", 128'(d), 128'(32'h7FFF_FFFF));
    wr(6'd7, 32'h0);
  endtask

  task automatic t_func();
    logic [31:0] d;
    wr(6'd10, 32'h0000_0020);
    chk("R10 pin5 intermediate", 128'(pad_func[11:10]), 128'(2'b01));
    wr(6'd11, 32'h0000_0020);
    chk("R9 pin5 code3", 128'(pad_func[11:10]), 128'(2'b11));
    wr(6'd13, 32'h4000_0000);
    chk("R9 pin62 code2", 128'(pad_func[125:124]), 128'(2'b10));
    chk("R10 others zero", 128'(pad_func & ~(126'h3 << 10) & ~(126'h3 << 124)), 128'(0));
    rd(6'd11, d); chk("R9 plane1 low read", 128'(d), 128'(32'h0000_0020));
    rd(6'd12, d); chk("R9 plane0 high read", 128'(d), 128'(0));
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [N-1:0] po, pe;
    logic [2*N-1:0] pf;
    po = pad_out; pe = pad_oe; pf = pad_func;
    wr(6'd20, 32'hFFFF_FFFF);
    wr(6'd63, 32'hFFFF_FFFF);
    wr(6'd8, 32'hFFFF_FFFF);
    wr(6'd9, 32'hFFFF_FFFF);
    chk("R12 pad_out unchanged", 128'(pad_out), 128'(po));
    chk("R12 pad_oe unchanged", 128'(pad_oe), 128'(pe));
    chk("R12 pad_func unchanged", 128'(pad_func), 128'(pf));
    rd(6'd20, d); chk("R12 unmapped read", 128'(d), 128'(0));
  endtask

  task automatic t_rdata_hold();
    logic [31:0] d;
    wr(6'd0, 32'hCAFE_0001);
    rd(6'd0, d); chk("R13 read value", 128'(rdata), 128'(32'hCAFE_0001));
    idle(2);
    wr(6'd0, 32'h0000_0002);
    chk("R13 hold after write", 128'(rdata), 128'(32'hCAFE_0001));
  endtask

  initial begin
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_set_clr();
    t_oe_level();
    t_sync_latency();
    t_top_bit();
    t_func();
    t_unmapped();
    t_rdata_hold();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule